// File: doc/BRIEF.md
# Two-Key Register Write Unlock Gate

This block sits between a simple register bus and a peripheral's protected register file. Writes to the protected registers are held off until software has stored two fixed 32-bit magic words, in a set order, into two dedicated key slots on the same bus. While the gate is closed, every write aimed at a protected register is discarded without notice. Reads are forwarded at all times.

A three-state controller tracks progress through the key sequence: closed, first key accepted, and open. Any key write carrying the wrong word closes the gate again. Writing zero to the first key slot is the usual way to close it. Writes to the key slots themselves never reach the register file.

The write qualifier is combinational from the bus strobe and the registered gate state. A protected write takes effect in the same cycle it is presented, and the decision uses the state from before that cycle's clock edge.

Top module: `reg_write_unlock`

## Requirements
- R1: After a cycle with `rst_n` low the gate is closed, so a protected write (`bus_wr` high, address not a key slot) gives `prot_wr` low.
- R2: A write of 0x83E70B13 to byte address 0x6C, followed later by a write of 0x95A4F1E0 to byte address 0x70, opens the gate. From the cycle after the second write, protected writes assert `prot_wr` in the same cycle as `bus_wr`.
- R3: While the gate is closed or holds only the first key, `prot_wr` stays low for every protected write.
- R4: `prot_rd` equals `bus_rd` in every cycle, whatever the gate state.
- R5: A correct second-key write when the first key has not been accepted leaves the gate closed. This covers a second key written first, and a second key written after a relock.
- R6: A write to address 0x6C of any word other than 0x83E70B13, including zero, closes the gate from every state.
- R7: A write to address 0x70 of any word other than 0x95A4F1E0 closes the gate from every state.
- R8: Writes to either key address never assert `prot_wr`. Protected writes and reads do not change the gate state. Rewriting either correct key while the gate is open keeps it open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle while high |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| prot_wr | output | 1 | Write strobe qualified for the protected register file |
| prot_rd | output | 1 | Read strobe forwarded to the protected register file |

## Verification
Both `prot_wr` and `prot_rd` are combinational, so they are due in the same cycle as the strobe. A key write changes the gate state at the next rising edge, so it first affects an access in the following cycle. The bench drives each access just after a falling edge and samples the outputs 1 ns later, before the next rising edge. It compares them against a reference model whose state it advances only after that sample. Directed sequences cover the unlock order, the relock cases and the out-of-order cases. Seeded random traffic then mixes correct keys, wrong keys, zero and protected accesses.

// File: rtl/unlock_gate_pkg.sv
// Shared types for the two-key unlock gate.
// Assumes: state encoding is private to the gate; nothing outside decodes it.
package unlock_gate_pkg;
    typedef enum logic [1:0] {
        GATE_CLOSED = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_state_e;
endpackage

// File: rtl/key_slot_match.sv
// Decodes one key slot: flags a write aimed at the slot and whether it
// carries the slot's magic word.
// Assumes: one bus write per cycle; the full word is compared.
module key_slot_match #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] SLOT_ADDR  = '0,
    parameter logic [DATA_W-1:0] SLOT_VALUE = '0
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              sel,
    output logic              hit,
    output logic              good
);
    // Address match and value compare for this slot.
    always_comb begin
        sel  = (addr == SLOT_ADDR);
        hit  = wr && sel;
        good = hit && (wdata == SLOT_VALUE);
    end
endmodule

// File: rtl/lock_fsm.sv
// Three-state lock controller: closed -> armed (first key) -> open (second key).
// Any wrong key word closes the gate. Correct keys while open keep it open.
// Assumes: k0_hit and k1_hit are never high together (distinct addresses).
module lock_fsm
    import unlock_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic k0_hit,
    input  logic k0_good,
    input  logic k1_hit,
    input  logic k1_good,
    output logic is_open
);
    gate_state_e st_q, st_d;

    // Next-state rule for key writes; other traffic leaves the state alone.
    always_comb begin
        st_d = st_q;
        if (k0_hit) begin
            if (!k0_good)               st_d = GATE_CLOSED;
            else if (st_q == GATE_OPEN) st_d = GATE_OPEN;
            else                        st_d = GATE_ARMED;
        end else if (k1_hit) begin
            if (k1_good && (st_q != GATE_CLOSED)) st_d = GATE_OPEN;
            else                                  st_d = GATE_CLOSED;
        end
    end

    // State register with synchronous reset to closed.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= GATE_CLOSED;
        else        st_q <= st_d;
    end

    // Open flag for the write qualifier.
    always_comb is_open = (st_q == GATE_OPEN);

    AST_RESET_CLOSES: assert property (@(posedge clk)
        !rst_n |=> (st_q == GATE_CLOSED)); // R1
    AST_OPEN_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> ($past(st_q) == GATE_ARMED) && $past(k1_good)); // R5
    AST_BAD_KEY0_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (k0_hit && !k0_good) |=> (st_q == GATE_CLOSED)); // R6
    AST_BAD_KEY1_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (k1_hit && !k1_good) |=> (st_q == GATE_CLOSED)); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!k0_hit && !k1_hit) |=> $stable(st_q)); // R8
endmodule

// File: rtl/reg_write_unlock.sv
// Write-protection gate in front of a register file. Protected writes pass
// only while both keys have been accepted in order. Reads always pass.
// Assumes: simple single-cycle valid strobes; key slots are not part of the
// protected file, so writes to them are never forwarded.
module reg_write_unlock #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] KEY0_ADDR  = 8'h6C,
    parameter logic [ADDR_W-1:0] KEY1_ADDR  = 8'h70,
    parameter logic [DATA_W-1:0] KEY0_VALUE = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY1_VALUE = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              prot_wr,
    output logic              prot_rd
);
    logic k0_sel, k0_hit, k0_good;
    logic k1_sel, k1_hit, k1_good;
    logic gate_open;

    key_slot_match #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SLOT_ADDR(KEY0_ADDR), .SLOT_VALUE(KEY0_VALUE)
    ) i_key0 (
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .sel(k0_sel), .hit(k0_hit), .good(k0_good)
    );

    key_slot_match #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SLOT_ADDR(KEY1_ADDR), .SLOT_VALUE(KEY1_VALUE)
    ) i_key1 (
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .sel(k1_sel), .hit(k1_hit), .good(k1_good)
    );

    lock_fsm i_fsm (
        .clk(clk), .rst_n(rst_n),
        .k0_hit(k0_hit), .k0_good(k0_good),
        .k1_hit(k1_hit), .k1_good(k1_good),
        .is_open(gate_open)
    );

    // Qualify protected writes; reads go straight through.
    always_comb begin
        prot_wr = bus_wr && gate_open && !k0_sel && !k1_sel;
        prot_rd = bus_rd;
    end

    AST_KEY_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (k0_hit || k1_hit) |-> !prot_wr); // R8
    AST_CLOSED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |-> !prot_wr); // R3
endmodule

// File: tb/test_reg_write_unlock.sv
module test_reg_write_unlock;
    localparam logic [7:0]  K0A = 8'h6C;
    localparam logic [7:0]  K1A = 8'h70;
    localparam logic [31:0] K0V = 32'h83E7_0B13;
    localparam logic [31:0] K1V = 32'h95A4_F1E0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic prot_wr, prot_rd;

    int checks = 0;
    int fails  = 0;
    int mstate = 0; // 0 closed, 1 armed, 2 open
    int seed_dummy;

    always #4 clk = ~clk;

    reg_write_unlock i_reg_write_unlock (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .prot_wr(prot_wr), .prot_rd(prot_rd)
    );

    function automatic int model_next(int s, logic wr, logic [7:0] a, logic [31:0] d);
        if (!wr) return s;
        if (a == K0A) return (d != K0V) ? 0 : ((s == 2) ? 2 : 1);
        if (a == K1A) return (d == K1V && s != 0) ? 2 : 0;
        return s;
    endfunction

    function automatic logic model_wr(int s, logic wr, logic [7:0] a);
        return wr && (s == 2) && (a != K0A) && (a != K1A);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One bus cycle: drive after negedge, sample before the next posedge.
    task automatic access(string req, logic wr, logic rd, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        chk(req, prot_wr, model_wr(mstate, wr, a));
        chk("R4", prot_rd, rd);
        mstate = model_next(mstate, wr, a, d);
    endtask

    task automatic probe(string req);
        access(req, 1'b1, 1'b0, 8'h10, 32'h1234);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd5150);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        mstate = 0;
        probe("R1");                                  // reset state closed
        access("R5", 1, 0, K1A, K1V); probe("R5");    // second key first
        access("R3", 1, 0, K0A, K0V); probe("R3");    // armed only
        access("R2", 1, 1, K1A, K1V); probe("R2");    // now open
        chk("R2", prot_wr, 1'b1);
        access("R8", 1, 0, K0A, K0V); probe("R8");    // re-key while open
        access("R8", 1, 0, K1A, K1V); probe("R8");
        access("R8", 0, 1, 8'h20, 32'h0); probe("R8"); // read leaves state
        access("R6", 1, 0, K0A, 32'h0); probe("R6");  // zero relocks
        chk("R6", prot_wr, 1'b0);
        access("R5", 1, 0, K1A, K1V); probe("R5");    // after relock
        access("R7", 1, 0, K0A, K0V);
        access("R7", 1, 0, K1A, 32'h95A4_F1E1); probe("R7");
        access("R2", 1, 0, K0A, K0V);
        access("R8", 1, 0, 8'h04, 32'h5);             // protected write while armed
        access("R2", 1, 0, K1A, K1V); probe("R2");
        access("R7", 1, 0, K1A, 32'h0); probe("R7");
        access("R6", 1, 0, K0A, K0V); access("R6", 1, 0, K1A, K1V);
        access("R6", 1, 0, K0A, K0V ^ 32'h1); probe("R6");
        // reset from open
        access("R1", 1, 0, K0A, K0V); access("R1", 1, 0, K1A, K1V);
        @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0;
        @(negedge clk); rst_n = 1'b1; mstate = 0;
        probe("R1");
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            logic [7:0]  a;
            logic [31:0] d;
            if (sel < 3)      a = K0A;
            else if (sel < 6) a = K1A;
            else              a = 8'($urandom_range(0, 255));
            case ($urandom_range(0, 3))
                0, 1: d = (a == K1A) ? K1V : K0V;
                2:    d = 32'h0;
                default: d = $urandom;
            endcase
            access("R8", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, d);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule